// File: doc/BRIEF.md
# Flyby DMA Channel

This block is one direct-memory-access channel that moves data between a peripheral and memory. Each data item takes a single bus cycle. The channel never holds the data. When the peripheral raises its request, the channel asks the processor for the system bus. Once the bus is granted, the channel drives the memory address and the memory read or write strobe. In the same cycle it drives the acknowledge that tells the peripheral to put data on the bus or to take it off.

Software loads a start address, an item count and a control word. The control word picks the direction and the pacing mode:
- **Single:** one item for each rising request, with the bus handed back after every item.
- **Block:** one request runs the whole count without letting go of the bus.
- **Demand:** the channel streams while the request stays high and gives the bus back while it is low.

The address steps by one word for each item and the count steps down. When the count runs out, the channel raises a done level and a one-cycle interrupt pulse.

Top module: `flyby_dma_chan`

## Requirements
- R1: After a synchronous reset, `busy`, `bus_req`, `dev_ack`, `mem_rd`, `mem_wr`, `done`, `irq` and `err` are all low.
- R2: `dev_ack`, `mem_rd` and `mem_wr` are high only in a cycle in which `bus_gnt` and `bus_req` are both high. Without a grant, no item moves however long the request is held.
- R3: Each cycle with `dev_ack` high moves exactly one item.
  - In that cycle exactly one strobe is high: `mem_wr` for direction 00 (peripheral to memory) or `mem_rd` for direction 01 (memory to peripheral).
  - `mem_addr` shows the programmed start address on the first item and rises by one on each later item.
- R4: Software writes use `cfg_sel` 0 for the start address, 1 for the item count and 2 for the control word.
  - Control bits [1:0] hold the direction and bits [3:2] hold the mode (00 single, 01 block, 10 demand). Bit 4 starts the run.
  - A start is rejected if the direction is 10 (memory to memory) or 11, the mode is 11, or the count is zero. A rejected start sets `err` and leaves the channel idle with `bus_req` low.
  - A start that is accepted clears `err`.
- R5: In single mode the channel moves one item per request assertion. `bus_req` falls after every item, and a request held high moves no second item until it has gone low and risen again.
- R6: In block mode a single request pulse runs the whole count, and `bus_req` stays high from the first item to the last.
- R7: In demand mode items move while `dev_req` stays high. When the request drops, the bus is released and items stop. When the request returns, the channel arbitrates again and continues where it left off.
- R8: The cycle after the last item, `dev_ack` and `bus_req` are low, `busy` is low, `done` is high and `irq` is high for exactly one cycle. `done` stays high until the next accepted start.
- R9: Register writes while `busy` is high are ignored. The address, count, direction and mode of the current run do not change.
- R10: If `bus_gnt` is removed in the middle of a run, the acknowledge stops while `bus_req` stays high. The run resumes when the grant returns, with no item lost or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 control |
| cfg_wdata | input | CFG_W | Register write data |
| dev_req | input | 1 | Peripheral transfer request |
| dev_ack | output | 1 | Peripheral acknowledge, high during each item's bus cycle |
| bus_req | output | 1 | Bus ownership request to the processor |
| bus_gnt | input | 1 | Bus grant from the processor |
| mem_addr | output | ADDR_W | Memory word address |
| mem_rd | output | 1 | Memory read strobe (memory to peripheral) |
| mem_wr | output | 1 | Memory write strobe (peripheral to memory) |
| busy | output | 1 | Channel is running a transfer |
| done | output | 1 | Last run completed |
| irq | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last start attempt was rejected |

## Verification
Internal faults in this block show up quickly at the ports:
- A stuck or wrongly stepped sequencer state appears in the first bus cycle as an acknowledge without a grant, a missing bus release between single-mode items, or a dropped request in block mode.
- A faulty address or count path appears at completion as a gap or repeat in the logged address sequence, or as the wrong number of acknowledges.
- Write-lockout and rejection faults show one or two cycles after the offending write, through `mem_addr`, `err` and the number of items the run delivers afterwards.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;

  typedef enum logic [1:0] {
    DIR_DEV2MEM = 2'b00,
    DIR_MEM2DEV = 2'b01,
    DIR_MEM2MEM = 2'b10,
    DIR_RSVD    = 2'b11
  } dir_e;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_BLOCK  = 2'b01,
    MODE_DEMAND = 2'b10,
    MODE_RSVD   = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ARB,
    ST_XFER,
    ST_DROP
  } state_e;

  typedef struct packed {
    mode_e mode;
    dir_e  dir;
  } chan_cfg_t;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTL  = 2'd2;

  localparam int CTL_DIR_LSB  = 0;
  localparam int CTL_MODE_LSB = 2;
  localparam int CTL_GO_BIT   = 4;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import flyby_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 10,
  parameter int CFG_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              busy,
  output logic [ADDR_W-1:0] start_addr,
  output logic [CNT_W-1:0]  item_cnt,
  output chan_cfg_t         cfg_q,
  output logic              arm,
  output logic              err
);

  localparam int CTL_W = CTL_GO_BIT + 1;

  logic  locked;
  logic  go;
  dir_e  new_dir;
  mode_e new_mode;
  logic  dir_ok;
  logic  mode_ok;
  logic  cnt_ok;

  assign locked   = busy | arm;
  assign go       = cfg_wdata[CTL_GO_BIT];
  assign new_dir  = dir_e'(cfg_wdata[CTL_DIR_LSB +: 2]);
  assign new_mode = mode_e'(cfg_wdata[CTL_MODE_LSB +: 2]);
  assign dir_ok   = (new_dir == DIR_DEV2MEM) || (new_dir == DIR_MEM2DEV);
  assign mode_ok  = (new_mode != MODE_RSVD);
  assign cnt_ok   = (item_cnt != '0);

  generate
    if (CFG_W < ADDR_W || CFG_W < CNT_W || CFG_W < CTL_W) begin : g_bad_width
      initial $error("dma_cfg_regs: CFG_W too narrow");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      start_addr <= '0;
      item_cnt   <= '0;
      cfg_q      <= '{mode: MODE_SINGLE, dir: DIR_DEV2MEM};
      arm        <= 1'b0;
      err        <= 1'b0;
    end else begin
      arm <= 1'b0;
      if (cfg_we && !locked) begin
        case (cfg_sel)
          SEL_ADDR: start_addr <= cfg_wdata[ADDR_W-1:0];
          SEL_CNT:  item_cnt   <= cfg_wdata[CNT_W-1:0];
          SEL_CTL: begin
            cfg_q.dir  <= new_dir;
            cfg_q.mode <= new_mode;
            if (go) begin
              if (dir_ok && mode_ok && cnt_ok) begin
                arm <= 1'b1;
                err <= 1'b0;
              end else begin
                err <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dma_addr_cnt.sv
module dma_addr_cnt #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);

  localparam logic [ADDR_W-1:0] ADDR_INC = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr     <= '0;
      remain_q <= '0;
    end else if (load) begin
      addr     <= load_addr;
      remain_q <= load_cnt;
    end else if (step) begin
      addr     <= addr + ADDR_INC;
      remain_q <= remain_q - CNT_ONE;
    end
  end

  assign last = (remain_q == CNT_ONE);

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import flyby_dma_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  arm,
  input  mode_e mode,
  input  logic  dev_req,
  input  logic  bus_gnt,
  input  logic  last,
  output logic  bus_req,
  output logic  step,
  output logic  busy,
  output logic  done,
  output logic  irq
);

  state_e state_q;
  state_e state_d;
  logic   finish;

  assign step    = (state_q == ST_XFER) && bus_gnt;
  assign bus_req = (state_q == ST_ARB) || (state_q == ST_XFER);
  assign busy    = (state_q != ST_IDLE);
  assign finish  = step && last;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (arm) state_d = ST_WAIT;
      ST_WAIT: if (dev_req) state_d = ST_ARB;
      ST_ARB:  if (bus_gnt) state_d = ST_XFER;
      ST_XFER: begin
        if (!bus_gnt) begin
          state_d = ST_ARB;
        end else if (last) begin
          state_d = ST_IDLE;
        end else begin
          case (mode)
            MODE_SINGLE: state_d = ST_DROP;
            MODE_BLOCK:  state_d = ST_XFER;
            MODE_DEMAND: state_d = dev_req ? ST_XFER : ST_WAIT;
            default:     state_d = ST_IDLE;
          endcase
        end
      end
      ST_DROP: if (!dev_req) state_d = ST_WAIT;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
      irq     <= 1'b0;
    end else begin
      state_q <= state_d;
      irq     <= finish;
      if (arm) done <= 1'b0;
      else if (finish) done <= 1'b1;
    end
  end

endmodule

// File: rtl/flyby_dma_chan.sv
module flyby_dma_chan
  import flyby_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 10,
  parameter int CFG_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              dev_req,
  output logic              dev_ack,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              busy,
  output logic              done,
  output logic              irq,
  output logic              err
);

  logic [ADDR_W-1:0] start_addr;
  logic [CNT_W-1:0]  item_cnt;
  chan_cfg_t         cfg_q;
  logic              arm;
  logic              step;
  logic              cnt_last;
  mode_e             run_mode;

  assign run_mode = cfg_q.mode;

  dma_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CFG_W(CFG_W)) regs_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .start_addr(start_addr),
    .item_cnt(item_cnt), .cfg_q(cfg_q), .arm(arm), .err(err)
  );

  dma_addr_cnt #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rst(rst), .load(arm), .load_addr(start_addr),
    .load_cnt(item_cnt), .step(step), .addr(mem_addr), .last(cnt_last)
  );

  dma_seq_fsm seq_i (
    .clk(clk), .rst(rst), .arm(arm), .mode(run_mode), .dev_req(dev_req),
    .bus_gnt(bus_gnt), .last(cnt_last), .bus_req(bus_req), .step(step),
    .busy(busy), .done(done), .irq(irq)
  );

  assign dev_ack = step;
  assign mem_wr  = step && (cfg_q.dir == DIR_DEV2MEM);
  assign mem_rd  = step && (cfg_q.dir == DIR_MEM2DEV);

endmodule

// File: rtl/flyby_dma_chk.sv
module flyby_dma_chk
  import flyby_dma_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              dev_req,
  input logic              dev_ack,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              busy,
  input logic              done,
  input logic              irq,
  input logic              err,
  input mode_e             mode,
  input logic              last
);

  p_ack_needs_gnt_r2: assert property (@(posedge clk) disable iff (rst)
    dev_ack |-> (bus_gnt && bus_req));

  p_strobe_only_with_ack_r2: assert property (@(posedge clk) disable iff (rst)
    !dev_ack |-> (!mem_rd && !mem_wr));

  p_one_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    dev_ack |-> ($countones({mem_rd, mem_wr}) == 1));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
    dev_ack |=> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  p_err_idle_r4: assert property (@(posedge clk) disable iff (rst)
    err |-> !busy);

  p_single_release_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SINGLE && dev_ack) |=> !bus_req);

  p_block_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_BLOCK && dev_ack && !last) |=> bus_req);

  p_demand_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_DEMAND && dev_ack && !last && dev_req) |=> bus_req);

  p_demand_pause_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_DEMAND && dev_ack && !dev_req) |=> !bus_req);

  p_irq_state_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> (done && !busy && !bus_req && !dev_ack));

  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  p_done_with_irq_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> irq);

  p_addr_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !dev_ack) |=> $stable(mem_addr));

  p_keep_req_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt) |=> bus_req);

endmodule

bind flyby_dma_chan flyby_dma_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .dev_req(dev_req), .dev_ack(dev_ack),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .busy(busy), .done(done),
  .irq(irq), .err(err), .mode(run_mode), .last(cnt_last)
);

// File: tb/flyby_dma_chan_tb_top.sv
module flyby_dma_chan_tb_top;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 10;
  localparam int CFG_W  = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst;
  logic              cfg_we;
  logic [1:0]        cfg_sel;
  logic [CFG_W-1:0]  cfg_wdata;
  logic              dev_req;
  logic              dev_ack;
  logic              bus_req;
  logic              bus_gnt;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_rd;
  logic              mem_wr;
  logic              busy;
  logic              done;
  logic              irq;
  logic              err;

  flyby_dma_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CFG_W(CFG_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .dev_req(dev_req), .dev_ack(dev_ack),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .busy(busy), .done(done),
    .irq(irq), .err(err)
  );

  int n_chk = 0;
  int n_err = 0;
  logic gnt_en = 1'b1;

  int n_items, wr_cnt, rd_cnt, arb_cnt, irq_cnt, irq_ok;
  logic [ADDR_W-1:0] log_a [64];
  logic req_prev = 1'b0;
  logic ack_prev = 1'b0;

  // Processor-side arbiter model: grants whenever asked and allowed.
  initial begin
    bus_gnt = 1'b0;
    forever begin
      @(negedge clk);
      bus_gnt = bus_req & gnt_en;
    end
  end

  // Bus monitor, sampled 1 ns after the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst) begin
        if (dev_ack) begin
          if (n_items < 64) log_a[n_items] = mem_addr;
          n_items++;
          if (mem_wr) wr_cnt++;
          if (mem_rd) rd_cnt++;
        end
        if (bus_req && !req_prev) arb_cnt++;
        if (irq) begin
          irq_cnt++;
          if (ack_prev && !dev_ack && !bus_req && done && !busy) irq_ok++;
        end
        req_prev = bus_req;
        ack_prev = dev_ack;
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic chk_eq(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic clr_log();
    n_items = 0; wr_cnt = 0; rd_cnt = 0; arb_cnt = 0; irq_cnt = 0; irq_ok = 0;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(logic [1:0] sel, logic [CFG_W-1:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [CFG_W-1:0] ctlw(logic [1:0] d, logic [1:0] m, logic go);
    return CFG_W'({go, m, d});
  endfunction

  task automatic start(int a, int n, logic [1:0] d, logic [1:0] m);
    cfg_write(2'd0, CFG_W'(a));
    cfg_write(2'd1, CFG_W'(n));
    cfg_write(2'd2, ctlw(d, m, 1'b1));
    cyc(2);
  endtask

  task automatic pulse_req();
    @(negedge clk); dev_req = 1'b1;
    @(negedge clk); dev_req = 1'b0;
  endtask

  task automatic wait_done(string rq, int maxc);
    int c = 0;
    while (!done && c < maxc) begin
      @(negedge clk);
      c++;
    end
    #2;
    chk_eq(rq, int'(done), 1);
  endtask

  task automatic chk_run(string rq, int base, int n, bit wr);
    int bad = 0;
    chk_eq(rq, n_items, n);
    for (int i = 0; i < n && i < 64; i++)
      if (int'(log_a[i]) != base + i) bad++;
    chk_eq(rq, bad, 0);
    chk_eq(rq, wr ? wr_cnt : rd_cnt, n);
    chk_eq(rq, wr ? rd_cnt : wr_cnt, 0);
  endtask

  task automatic t_reset();
    #2;
    chk_eq("R1", int'({busy, bus_req, dev_ack, mem_rd, mem_wr, done, irq, err}), 0);
  endtask

  task automatic t_block();
    @(negedge clk); clr_log();
    start(16'h100, 5, 2'b00, 2'b01);
    pulse_req();
    wait_done("R6", 100);
    chk_run("R3", 16'h100, 5, 1'b1);
    chk_eq("R6", arb_cnt, 1);
    chk_eq("R8", irq_cnt, 1);
    chk_eq("R8", irq_ok, 1);
    chk_eq("R8", int'({busy, bus_req}), 0);
  endtask

  task automatic t_single();
    @(negedge clk); clr_log();
    start(16'h200, 3, 2'b01, 2'b00);
    @(negedge clk); dev_req = 1'b1;
    cyc(15); #2;
    chk_eq("R5", n_items, 1);
    chk_eq("R5", int'(bus_req), 0);
    @(negedge clk); dev_req = 1'b0;
    cyc(2); dev_req = 1'b1;
    cyc(15); #2;
    chk_eq("R5", n_items, 2);
    @(negedge clk); dev_req = 1'b0;
    cyc(2); dev_req = 1'b1;
    wait_done("R5", 50);
    @(negedge clk); dev_req = 1'b0;
    chk_run("R3", 16'h200, 3, 1'b0);
    chk_eq("R5", arb_cnt, 3);
  endtask

  task automatic t_demand();
    int c = 0;
    int k;
    @(negedge clk); clr_log();
    start(16'h300, 6, 2'b00, 2'b10);
    @(negedge clk); dev_req = 1'b1;
    while (n_items < 1 && c < 30) begin
      @(negedge clk);
      c++;
    end
    dev_req = 1'b0;
    cyc(3); #2;
    k = n_items;
    chk_eq("R7", int'(k < 6 && k >= 1), 1);
    cyc(10); #2;
    chk_eq("R7", n_items, k);
    chk_eq("R7", int'(bus_req), 0);
    chk_eq("R7", int'(busy), 1);
    @(negedge clk); dev_req = 1'b1;
    wait_done("R7", 60);
    @(negedge clk); dev_req = 1'b0;
    chk_run("R7", 16'h300, 6, 1'b1);
    chk_eq("R7", arb_cnt, 2);
  endtask

  task automatic t_reject();
    @(negedge clk); clr_log();
    cfg_write(2'd0, 16'h0400);
    cfg_write(2'd1, 16'd4);
    cfg_write(2'd2, ctlw(2'b10, 2'b01, 1'b1));
    cyc(3); #2;
    chk_eq("R4", int'({err, busy, bus_req}), 3'b100);
    cfg_write(2'd2, ctlw(2'b00, 2'b11, 1'b1));
    cyc(3); #2;
    chk_eq("R4", int'({err, busy}), 2'b10);
    cfg_write(2'd1, 16'd0);
    cfg_write(2'd2, ctlw(2'b00, 2'b01, 1'b1));
    cyc(3); #2;
    chk_eq("R4", int'({err, busy}), 2'b10);
    chk_eq("R4", arb_cnt, 0);
    cfg_write(2'd1, 16'd1);
    cfg_write(2'd2, ctlw(2'b00, 2'b00, 1'b1));
    cyc(2); #2;
    chk_eq("R4", int'({err, busy}), 2'b01);
    pulse_req();
    wait_done("R4", 40);
    chk_run("R4", 16'h400, 1, 1'b1);
  endtask

  task automatic t_busy_write();
    @(negedge clk); clr_log();
    start(16'h40, 2, 2'b00, 2'b00);
    pulse_req();
    cyc(8); #2;
    chk_eq("R9", n_items, 1);
    cfg_write(2'd0, 16'h07F0);
    cfg_write(2'd1, 16'd9);
    cfg_write(2'd2, ctlw(2'b01, 2'b01, 1'b1));
    cyc(3); #2;
    chk_eq("R9", int'(mem_addr), 16'h41);
    chk_eq("R9", int'({err, busy}), 2'b01);
    pulse_req();
    cyc(12); #2;
    chk_eq("R9", int'(done), 1);
    chk_run("R9", 16'h40, 2, 1'b1);
  endtask

  task automatic t_grant();
    int c = 0;
    int k;
    @(negedge clk); clr_log();
    #1 gnt_en = 1'b0;
    start(16'h500, 4, 2'b00, 2'b01);
    pulse_req();
    cyc(10); #2;
    chk_eq("R2", int'({bus_req, dev_ack}), 2'b10);
    chk_eq("R2", n_items, 0);
    @(negedge clk); #1 gnt_en = 1'b1;
    wait_done("R2", 40);
    chk_run("R2", 16'h500, 4, 1'b1);

    @(negedge clk); clr_log();
    start(16'h600, 8, 2'b01, 2'b01);
    pulse_req();
    while (n_items < 3 && c < 30) begin
      @(negedge clk);
      c++;
    end
    #1 gnt_en = 1'b0;
    cyc(3); #2;
    k = n_items;
    cyc(5); #2;
    chk_eq("R10", n_items, k);
    chk_eq("R10", int'({bus_req, dev_ack}), 2'b10);
    @(negedge clk); #1 gnt_en = 1'b1;
    wait_done("R10", 40);
    chk_run("R10", 16'h600, 8, 1'b0);
  endtask

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0; dev_req = 1'b0;
    clr_log();
    cyc(5);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_block();
    t_single();
    t_demand();
    t_reject();
    t_busy_write();
    t_grant();
    cyc(5);
    summary();
    $finish;
  end

endmodule